// File: doc/BRIEF.md
# SMBus host transaction sequencer

This block sits on the host side of a system management bus and turns one requested transaction into the ordered list of bus primitives that carries it out: start, repeated start, write one byte, read one byte, send the host acknowledge bit, and stop. A separate bit-level engine carries out each primitive on the wires and reports back through a request/done handshake. The sequencer never touches clock or data lines itself.

A caller presents a transaction kind, a 7-bit target address, a command byte, a quick-command bit, a write count and a write buffer, and pulses `go`. The sequencer walks the fixed primitive order for that kind. It stops early and raises `err` when the target refuses a written byte or returns an unusable block length. When the closing stop has completed it pulses `done`. Received bytes land in `rd_buf`, byte 0 in bits 7:0, and `rd_count` holds how many data bytes were stored. The caller must keep `wr_buf` steady while `busy` is high. The small request fields are captured at `go`.

Top module: `smb_txn_seq`

## Requirements
- R1: Kind codes are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read. Primitive codes on `prim_op` are 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 host acknowledge bit (`prim_nack` 1 = NACK), 5 stop.
- R2: An address byte carries the address in bits 7:1 and the direction in bit 0 (1 read, 0 write). A quick command issues start, one write of the address with `quick_bit` in bit 0, then stop.
- R3: Send byte issues start, address+write, `wr_buf[7:0]`, stop. Receive byte issues start, address+read, one read, host NACK, stop, and stores the byte.
- R4: Write byte sends address+write, command and one data byte, then stop. Read byte sends address+write and command, then repeated start (not stop), address+read, one read, host NACK, stop.
- R5: Word data travels low byte first: `wr_buf[7:0]` then `wr_buf[15:8]`. A word read ACKs the first byte, NACKs the second, and stores them as `rd_buf[15:0]`.
- R6: A process call writes the command and a low/high word, then issues a repeated start, address+read, and reads a word with ACK then NACK before stop.
- R7: Block write sends the command, a count byte equal to `wr_count`, then exactly that many bytes from `wr_buf` starting at byte 0, then stop.
- R8: In a block read the first byte read is a length. When it lies in 1..32 it is ACKed and that many data bytes follow. Every data byte is ACKed except the final one, which is NACKed. `rd_count` equals the length.
- R9: A block-read length of 0 or above 32 is NACKed at once and followed by stop. `err` is raised and `rd_count` stays 0.
- R10: A target NACK on any written byte (address, command, count or data) makes stop the next primitive, and `err` is raised.
- R11: Only one primitive is requested at a time. `prim_req` holds its op steady until `prim_done` and drops for at least one cycle between primitives. `done` is high for exactly one cycle after the stop completes, and `busy` is low from then on.
- R12: A request with a kind code above 9, or a block write with `wr_count` of 0 or above 32, issues no primitive. It answers with `done` and `err` in the cycle after `go`.
- R13: A `go` pulse while `busy` is high is ignored. The running transaction's primitive order is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a transaction (accepted while idle) |
| txn_kind | input | 4 | Transaction kind code (R1) |
| dev_addr | input | 7 | Target address |
| cmd_byte | input | 8 | Command byte |
| quick_bit | input | 1 | Direction bit of a quick command |
| wr_count | input | 6 | Block write length |
| wr_buf | input | 256 | Bytes to write, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction failed or was refused |
| rd_buf | output | 256 | Received data bytes, byte 0 in bits 7:0 |
| rd_count | output | 6 | Number of data bytes received |
| prim_req | output | 1 | Primitive request to the bit engine |
| prim_op | output | 3 | Primitive code (R1) |
| prim_wdata | output | 8 | Byte for a write primitive |
| prim_nack | output | 1 | Host acknowledge value for the ack primitive, 1 = NACK |
| prim_done | input | 1 | Bit engine finished the requested primitive |
| prim_rdata | input | 8 | Byte returned by a read primitive |
| prim_dev_nack | input | 1 | Target NACKed the written byte |

## Verification
The hardest cases to reach are the ones the target decides, not the caller. These are a block length outside 1..32 and a refusal landing in the middle of a block write. The bench reaches them with a scripted bit-engine model. The model returns a chosen sequence of read bytes and NACKs the write primitive at a chosen index. This lets the length byte be 0 or 33 and lets the abort fall on an address, a command or a later data byte. The model logs every primitive requested, and each run compares that log against the order worked out from the requirements.

// File: rtl/smb_seq_pkg.sv
// Shared encodings for the SMBus host transaction sequencer.
package smb_seq_pkg;

    // Transaction kinds requested by the caller.
    typedef enum logic [3:0] {
        K_QUICK   = 4'd0,
        K_SEND    = 4'd1,
        K_RECV    = 4'd2,
        K_WR_BYTE = 4'd3,
        K_RD_BYTE = 4'd4,
        K_WR_WORD = 4'd5,
        K_RD_WORD = 4'd6,
        K_PCALL   = 4'd7,
        K_BLK_WR  = 4'd8,
        K_BLK_RD  = 4'd9
    } kind_e;

    localparam logic [3:0] KIND_LAST = 4'd9;

    // Primitive codes handed to the bit-level engine.
    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_ACK    = 3'd4,
        OP_STOP   = 3'd5
    } prim_op_e;

    // Sequencer steps; each non-idle step issues one primitive (two for reads).
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_Q,
        ST_ADDR_W,
        ST_CMD,
        ST_CNT_W,
        ST_DATA_W,
        ST_RSTART,
        ST_ADDR_R,
        ST_CNT_R,
        ST_DATA_R,
        ST_STOP
    } step_e;

endpackage

// File: rtl/smb_seq_ctrl.sv
// Step controller: walks the primitive order of one transaction.
// Assumes the bit engine pulses prim_done once per request and that
// MAX_BLK fits in CW bits with CW <= 8.
module smb_seq_ctrl
    import smb_seq_pkg::*;
#(
    parameter int MAX_BLK = 32,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [3:0]    kind_in,
    input  logic [6:0]    addr_in,
    input  logic [7:0]    cmd_in,
    input  logic          quick_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          prim_done,
    input  logic [7:0]    prim_rdata,
    input  logic          prim_dev_nack,
    output step_e         st_o,
    output logic [6:0]    addr_o,
    output logic [7:0]    cmd_o,
    output logic          quick_o,
    output logic [CW-1:0] wcnt_o,
    output logic [CW-1:0] idx_o,
    output logic          req_o,
    output prim_op_e      op_o,
    output logic          nack_o,
    output logic          byte_we_o,
    output logic          clr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);
    localparam logic [CW-1:0] MAXC = CW'(MAX_BLK);
    localparam logic [7:0]    MAX8 = 8'(MAX_BLK);

    step_e         st, nst;
    kind_e         kind_q;
    logic [6:0]    addr_q;
    logic [7:0]    cmd_q;
    logic          quick_q;
    logic [CW-1:0] wcnt_q, n_q, idx_q, n_nxt, idx_nxt;
    logic          ack_ph, ack_nxt, cnt_bad, bad_nxt, set_err;
    logic          req_q, done_q, err_q;
    logic          fin, last, refuse;

    assign fin    = req_q & prim_done;
    assign last   = (idx_q + ONE) == n_q;
    assign refuse = (kind_in > KIND_LAST) ||
                    (kind_in == K_BLK_WR && (cnt_in == '0 || cnt_in > MAXC));

    // Next step, length and index once the current primitive completes.
    always_comb begin
        nst     = st;
        n_nxt   = n_q;
        idx_nxt = idx_q;
        ack_nxt = ack_ph;
        bad_nxt = cnt_bad;
        set_err = 1'b0;
        case (st)
            ST_START: begin
                if (kind_q == K_QUICK)     nst = ST_ADDR_Q;
                else if (kind_q == K_RECV) nst = ST_ADDR_R;
                else                       nst = ST_ADDR_W;
            end
            ST_ADDR_Q: begin
                nst     = ST_STOP;
                set_err = prim_dev_nack;
            end
            ST_ADDR_W: begin
                if (prim_dev_nack) begin
                    nst = ST_STOP; set_err = 1'b1;
                end else if (kind_q == K_SEND) begin
                    nst = ST_DATA_W; n_nxt = ONE; idx_nxt = '0;
                end else begin
                    nst = ST_CMD;
                end
            end
            ST_CMD: begin
                idx_nxt = '0;
                if (prim_dev_nack) begin
                    nst = ST_STOP; set_err = 1'b1;
                end else begin
                    case (kind_q)
                        K_WR_BYTE:         begin nst = ST_DATA_W; n_nxt = ONE; end
                        K_WR_WORD, K_PCALL: begin nst = ST_DATA_W; n_nxt = TWO; end
                        K_BLK_WR:          nst = ST_CNT_W;
                        default:           nst = ST_RSTART;
                    endcase
                end
            end
            ST_CNT_W: begin
                if (prim_dev_nack) begin
                    nst = ST_STOP; set_err = 1'b1;
                end else begin
                    nst = ST_DATA_W; n_nxt = wcnt_q; idx_nxt = '0;
                end
            end
            ST_DATA_W: begin
                if (prim_dev_nack) begin
                    nst = ST_STOP; set_err = 1'b1;
                end else if (last) begin
                    nst = (kind_q == K_PCALL) ? ST_RSTART : ST_STOP;
                end else begin
                    idx_nxt = idx_q + ONE;
                end
            end
            ST_RSTART: nst = ST_ADDR_R;
            ST_ADDR_R: begin
                idx_nxt = '0;
                ack_nxt = 1'b0;
                if (prim_dev_nack) begin
                    nst = ST_STOP; set_err = 1'b1;
                end else if (kind_q == K_BLK_RD) begin
                    nst = ST_CNT_R;
                end else if (kind_q == K_RD_WORD || kind_q == K_PCALL) begin
                    nst = ST_DATA_R; n_nxt = TWO;
                end else begin
                    nst = ST_DATA_R; n_nxt = ONE;
                end
            end
            ST_CNT_R: begin
                if (!ack_ph) begin
                    ack_nxt = 1'b1;
                    bad_nxt = (prim_rdata == 8'd0) || (prim_rdata > MAX8);
                    n_nxt   = prim_rdata[CW-1:0];
                end else begin
                    ack_nxt = 1'b0;
                    idx_nxt = '0;
                    if (cnt_bad) begin
                        nst = ST_STOP; set_err = 1'b1;
                    end else begin
                        nst = ST_DATA_R;
                    end
                end
            end
            ST_DATA_R: begin
                if (!ack_ph) begin
                    ack_nxt = 1'b1;
                end else begin
                    ack_nxt = 1'b0;
                    if (last) nst = ST_STOP;
                    else      idx_nxt = idx_q + ONE;
                end
            end
            ST_STOP: nst = ST_IDLE;
            default: nst = ST_IDLE;
        endcase
    end

    // Request handshake, step register and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            kind_q  <= K_QUICK;
            addr_q  <= '0;
            cmd_q   <= '0;
            quick_q <= 1'b0;
            wcnt_q  <= '0;
            n_q     <= '0;
            idx_q   <= '0;
            ack_ph  <= 1'b0;
            cnt_bad <= 1'b0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_IDLE) begin
                req_q <= 1'b0;
                if (go) begin
                    err_q <= refuse;
                    if (refuse) begin
                        done_q <= 1'b1;
                    end else begin
                        st      <= ST_START;
                        kind_q  <= kind_e'(kind_in);
                        addr_q  <= addr_in;
                        cmd_q   <= cmd_in;
                        quick_q <= quick_in;
                        wcnt_q  <= cnt_in;
                        ack_ph  <= 1'b0;
                        cnt_bad <= 1'b0;
                    end
                end
            end else if (!req_q) begin
                req_q <= 1'b1;
            end else if (fin) begin
                req_q   <= 1'b0;
                st      <= nst;
                n_q     <= n_nxt;
                idx_q   <= idx_nxt;
                ack_ph  <= ack_nxt;
                cnt_bad <= bad_nxt;
                err_q   <= err_q | set_err;
                if (st == ST_STOP) done_q <= 1'b1;
            end
        end
    end

    // Primitive code and host acknowledge value for the current step.
    always_comb begin
        case (st)
            ST_START:  op_o = OP_START;
            ST_RSTART: op_o = OP_RSTART;
            ST_STOP:   op_o = OP_STOP;
            ST_CNT_R, ST_DATA_R: op_o = ack_ph ? OP_ACK : OP_READ;
            default:   op_o = OP_WRITE;
        endcase
        nack_o = (st == ST_CNT_R) ? cnt_bad : last;
    end

    assign st_o      = st;
    assign addr_o    = addr_q;
    assign cmd_o     = cmd_q;
    assign quick_o   = quick_q;
    assign wcnt_o    = wcnt_q;
    assign idx_o     = idx_q;
    assign req_o     = req_q;
    assign byte_we_o = fin && (st == ST_DATA_R) && !ack_ph;
    assign clr_o     = go && (st == ST_IDLE);
    assign busy_o    = (st != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;

    // R11: a pending request keeps its op until the engine answers.
    a_r11_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !prim_done) |=> (req_q && $stable(op_o)));

    // R11: no request while idle.
    a_r11_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !req_q);

    // R11: completion of stop is followed by done and idle.
    a_r11_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && op_o == OP_STOP) |=> (done_q && !busy_o));

    // R10: a refused written byte leads straight to stop with error.
    a_r10_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && op_o == OP_WRITE && prim_dev_nack) |=> (st == ST_STOP && err_q));

    // R8: data index stays inside the current length.
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA_R || st == ST_DATA_W) |-> (idx_q < n_q));

endmodule

// File: rtl/smb_tx_pick.sv
// Byte selector: forms the byte sent by the current write step.
// Assumes wr_buf is held steady by the caller while a transaction runs.
module smb_tx_pick
    import smb_seq_pkg::*;
#(
    parameter int MAX_BLK = 32,
    parameter int CW      = 6
) (
    input  step_e                  st,
    input  logic [6:0]             addr,
    input  logic [7:0]             cmd,
    input  logic                   quick,
    input  logic [CW-1:0]          wcnt,
    input  logic [CW-1:0]          idx,
    input  logic [MAX_BLK*8-1:0]   wr_buf,
    output logic [7:0]             tx_byte
);

    // Address byte, command, count or buffer byte depending on step.
    always_comb begin
        case (st)
            ST_ADDR_Q: tx_byte = {addr, quick};
            ST_ADDR_W: tx_byte = {addr, 1'b0};
            ST_ADDR_R: tx_byte = {addr, 1'b1};
            ST_CMD:    tx_byte = cmd;
            ST_CNT_W:  tx_byte = 8'(wcnt);
            ST_DATA_W: tx_byte = wr_buf[{idx, 3'b000} +: 8];
            default:   tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/smb_rx_store.sv
// Receive store: captures read data bytes and counts them.
// Assumes idx stays below MAX_BLK whenever byte_we is high.
module smb_rx_store #(
    parameter int MAX_BLK = 32,
    parameter int CW      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 byte_we,
    input  logic [CW-1:0]        idx,
    input  logic [7:0]           rdata,
    output logic [MAX_BLK*8-1:0] rd_buf,
    output logic [CW-1:0]        rd_count
);

    localparam logic [CW-1:0] ONE = CW'(1);

    for (genvar i = 0; i < MAX_BLK; i++) begin : g_byte
        // Write one buffer byte when its slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_buf[i*8 +: 8] <= 8'h00;
            else if (byte_we && idx == CW'(i))
                rd_buf[i*8 +: 8] <= rdata;
        end
    end

    // Count of bytes stored in this transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_count <= '0;
        else if (clr)     rd_count <= '0;
        else if (byte_we) rd_count <= idx + ONE;
    end

    // R8: stores only land inside the buffer.
    a_r8_we_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |-> (idx < CW'(MAX_BLK)));

endmodule

// File: rtl/smb_txn_seq.sv
// SMBus host transaction sequencer top: controller, byte selector and
// receive store. Assumes one bit-level engine answers each prim_req
// with a single prim_done pulse.
module smb_txn_seq
    import smb_seq_pkg::*;
#(
    parameter int MAX_BLK = 32,
    localparam int CW     = $clog2(MAX_BLK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [3:0]           txn_kind,
    input  logic [6:0]           dev_addr,
    input  logic [7:0]           cmd_byte,
    input  logic                 quick_bit,
    input  logic [CW-1:0]        wr_count,
    input  logic [MAX_BLK*8-1:0] wr_buf,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [MAX_BLK*8-1:0] rd_buf,
    output logic [CW-1:0]        rd_count,
    output logic                 prim_req,
    output logic [2:0]           prim_op,
    output logic [7:0]           prim_wdata,
    output logic                 prim_nack,
    input  logic                 prim_done,
    input  logic [7:0]           prim_rdata,
    input  logic                 prim_dev_nack
);

    step_e         st;
    prim_op_e      op;
    logic [6:0]    addr_q;
    logic [7:0]    cmd_q;
    logic          quick_q;
    logic [CW-1:0] wcnt_q, idx;
    logic          byte_we, clr;

    smb_seq_ctrl #(.MAX_BLK(MAX_BLK), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go),
        .kind_in(txn_kind), .addr_in(dev_addr), .cmd_in(cmd_byte),
        .quick_in(quick_bit), .cnt_in(wr_count),
        .prim_done(prim_done), .prim_rdata(prim_rdata),
        .prim_dev_nack(prim_dev_nack),
        .st_o(st), .addr_o(addr_q), .cmd_o(cmd_q), .quick_o(quick_q),
        .wcnt_o(wcnt_q), .idx_o(idx), .req_o(prim_req), .op_o(op),
        .nack_o(prim_nack), .byte_we_o(byte_we), .clr_o(clr),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    smb_tx_pick #(.MAX_BLK(MAX_BLK), .CW(CW)) u_pick (
        .st(st), .addr(addr_q), .cmd(cmd_q), .quick(quick_q),
        .wcnt(wcnt_q), .idx(idx), .wr_buf(wr_buf), .tx_byte(prim_wdata)
    );

    smb_rx_store #(.MAX_BLK(MAX_BLK), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .byte_we(byte_we),
        .idx(idx), .rdata(prim_rdata), .rd_buf(rd_buf), .rd_count(rd_count)
    );

    assign prim_op = op;

endmodule

// File: tb/tb_smb_txn_seq.sv
// Directed bench with a scripted bit-engine model that logs primitives.
module tb_smb_txn_seq;

    localparam int CLK_P = 10;
    localparam int MAXB  = 32;
    localparam int CW    = 6;
    localparam int P_ST = 0, P_RS = 1, P_WR = 2, P_RD = 3, P_AK = 4, P_SP = 5;

    logic clk, rst_n, go, quick_bit, busy, done, err;
    logic [3:0] txn_kind;
    logic [6:0] dev_addr;
    logic [7:0] cmd_byte;
    logic [CW-1:0] wr_count, rd_count;
    logic [MAXB*8-1:0] wr_buf, rd_buf;
    logic prim_req, prim_nack, prim_done, prim_dev_nack;
    logic [2:0] prim_op;
    logic [7:0] prim_wdata, prim_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] rsp [0:63];
    int rsp_ptr, nack_at, wr_seen, log_n, exp_n;
    int log_op [0:127];
    int log_dat [0:127];
    int exp_op [0:127];
    int exp_dat [0:127];

    smb_txn_seq dut (
        .clk(clk), .rst_n(rst_n), .go(go), .txn_kind(txn_kind),
        .dev_addr(dev_addr), .cmd_byte(cmd_byte), .quick_bit(quick_bit),
        .wr_count(wr_count), .wr_buf(wr_buf), .busy(busy), .done(done),
        .err(err), .rd_buf(rd_buf), .rd_count(rd_count),
        .prim_req(prim_req), .prim_op(prim_op), .prim_wdata(prim_wdata),
        .prim_nack(prim_nack), .prim_done(prim_done),
        .prim_rdata(prim_rdata), .prim_dev_nack(prim_dev_nack)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // Bit-engine model: logs each request and answers two cycles later.
    initial begin
        prim_done = 1'b0; prim_rdata = 8'h00; prim_dev_nack = 1'b0;
        forever begin
            @(negedge clk);
            prim_done = 1'b0;
            prim_dev_nack = 1'b0;
            if (prim_req) begin
                if (log_n < 128) begin
                    log_op[log_n]  = int'(prim_op);
                    log_dat[log_n] = (prim_op == 3'd2) ? int'(prim_wdata) :
                                     (prim_op == 3'd4) ? int'(prim_nack) : 0;
                end
                log_n++;
                if (prim_op == 3'd3) begin
                    prim_rdata = rsp[rsp_ptr];
                    if (rsp_ptr < 63) rsp_ptr++;
                end
                if (prim_op == 3'd2) begin
                    prim_dev_nack = (wr_seen == nack_at);
                    wr_seen++;
                end
                repeat (2) @(negedge clk);
                prim_done = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic prep();
        exp_n = 0; log_n = 0; rsp_ptr = 0; wr_seen = 0; nack_at = -1;
    endtask

    task automatic push(input int op, input int dat);
        exp_op[exp_n] = op; exp_dat[exp_n] = dat; exp_n++;
    endtask

    task automatic cmp_seq(input string tag);
        int bad;
        checks++;
        bad = 0;
        if (log_n != exp_n) begin
            bad = 1;
            $display("FAIL %s primitive count: actual %0d expected %0d", tag, log_n, exp_n);
        end else begin
            for (int i = 0; i < exp_n; i++) begin
                if (bad == 0 && (log_op[i] != exp_op[i] || log_dat[i] != exp_dat[i])) begin
                    bad = 1;
                    $display("FAIL %s primitive %0d: actual op %0d data %0h expected op %0d data %0h",
                             tag, i, log_op[i], log_dat[i], exp_op[i], exp_dat[i]);
                end
            end
        end
        if (bad != 0) errors++;
    endtask

    // Issue one request and wait for its done pulse.
    task automatic run(input string tag, input int kind, input int addr, input int cmd,
                       input int qb, input int cnt, output int got_err, output int got_cnt);
        int n;
        @(negedge clk);
        txn_kind = 4'(kind); dev_addr = 7'(addr); cmd_byte = 8'(cmd);
        quick_bit = 1'(qb); wr_count = CW'(cnt); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, "done seen", int'(done), 1);
        got_err = int'(err);
        got_cnt = int'(rd_count);
        @(negedge clk);
        chk("R11", "done one cycle", int'(done), 0);
        chk("R11", "idle after done", int'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R11", "reset busy", int'(busy), 0);
        chk("R11", "reset done", int'(done), 0);
        chk("R11", "reset req", int'(prim_req), 0);
        chk("R8", "reset rd_count", int'(rd_count), 0);
    endtask

    task automatic t_quick(input int qb);
        int e, c;
        prep();
        push(P_ST, 0); push(P_WR, (8'h2A << 1) | qb); push(P_SP, 0);
        run("R2", 0, 8'h2A, 0, qb, 0, e, c);
        cmp_seq("R2");
        chk("R2", "quick err", e, 0);
    endtask

    task automatic t_send();
        int e, c;
        prep();
        wr_buf[7:0] = 8'h3C;
        push(P_ST, 0); push(P_WR, 8'h22); push(P_WR, 8'h3C); push(P_SP, 0);
        run("R3", 1, 8'h11, 0, 0, 0, e, c);
        cmp_seq("R1,R3");
        chk("R3", "send err", e, 0);
    endtask

    task automatic t_recv();
        int e, c;
        prep();
        rsp[0] = 8'h9E;
        push(P_ST, 0); push(P_WR, 8'h23); push(P_RD, 0); push(P_AK, 1); push(P_SP, 0);
        run("R3", 2, 8'h11, 0, 0, 0, e, c);
        cmp_seq("R3");
        chk("R3", "recv byte", int'(rd_buf[7:0]), 8'h9E);
        chk("R3", "recv count", c, 1);
    endtask

    task automatic t_byte_rw();
        int e, c;
        prep();
        wr_buf[7:0] = 8'hE1;
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h07); push(P_WR, 8'hE1); push(P_SP, 0);
        run("R4", 3, 8'h50, 8'h07, 0, 0, e, c);
        cmp_seq("R4");
        prep();
        rsp[0] = 8'h5A;
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h07); push(P_RS, 0);
        push(P_WR, 8'hA1); push(P_RD, 0); push(P_AK, 1); push(P_SP, 0);
        run("R4", 4, 8'h50, 8'h07, 0, 0, e, c);
        cmp_seq("R4");
        chk("R4", "read byte", int'(rd_buf[7:0]), 8'h5A);
        chk("R4", "read byte err", e, 0);
    endtask

    task automatic t_word_rw();
        int e, c;
        prep();
        wr_buf[15:0] = 16'hBEEF;
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h10);
        push(P_WR, 8'hEF); push(P_WR, 8'hBE); push(P_SP, 0);
        run("R5", 5, 8'h50, 8'h10, 0, 0, e, c);
        cmp_seq("R5");
        prep();
        rsp[0] = 8'h34; rsp[1] = 8'h12;
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h10); push(P_RS, 0);
        push(P_WR, 8'hA1); push(P_RD, 0); push(P_AK, 0); push(P_RD, 0); push(P_AK, 1); push(P_SP, 0);
        run("R5", 6, 8'h50, 8'h10, 0, 0, e, c);
        cmp_seq("R5");
        chk("R5", "read word", int'(rd_buf[15:0]), 16'h1234);
        chk("R5", "read word count", c, 2);
    endtask

    task automatic t_pcall();
        int e, c;
        prep();
        wr_buf[15:0] = 16'hCAFE;
        rsp[0] = 8'h78; rsp[1] = 8'h56;
        push(P_ST, 0); push(P_WR, 8'h84); push(P_WR, 8'h33); push(P_WR, 8'hFE); push(P_WR, 8'hCA);
        push(P_RS, 0); push(P_WR, 8'h85); push(P_RD, 0); push(P_AK, 0); push(P_RD, 0); push(P_AK, 1);
        push(P_SP, 0);
        run("R6", 7, 8'h42, 8'h33, 0, 0, e, c);
        cmp_seq("R6");
        chk("R6", "pcall word", int'(rd_buf[15:0]), 16'h5678);
        chk("R6", "pcall err", e, 0);
    endtask

    task automatic t_blk_wr(input int n);
        int e, c;
        prep();
        for (int i = 0; i < MAXB; i++) wr_buf[i*8 +: 8] = 8'(8'hA0 + i);
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h20); push(P_WR, n);
        for (int i = 0; i < n; i++) push(P_WR, 8'hA0 + i);
        push(P_SP, 0);
        run("R7", 8, 8'h50, 8'h20, 0, n, e, c);
        cmp_seq("R7");
        chk("R7", "block write err", e, 0);
    endtask

    task automatic t_blk_rd(input int n);
        int e, c, ok;
        prep();
        rsp[0] = 8'(n);
        for (int i = 0; i < n; i++) rsp[i+1] = 8'(8'h40 + 3*i);
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h21); push(P_RS, 0);
        push(P_WR, 8'hA1); push(P_RD, 0); push(P_AK, 0);
        for (int i = 0; i < n; i++) begin
            push(P_RD, 0); push(P_AK, (i == n-1) ? 1 : 0);
        end
        push(P_SP, 0);
        run("R8", 9, 8'h50, 8'h21, 0, 0, e, c);
        cmp_seq("R8");
        chk("R8", "block read count", c, n);
        chk("R8", "block read err", e, 0);
        ok = 1;
        for (int i = 0; i < n; i++)
            if (rd_buf[i*8 +: 8] != 8'(8'h40 + 3*i)) ok = 0;
        chk("R8", "block read bytes", ok, 1);
    endtask

    task automatic t_blk_rd_bad(input int n);
        int e, c;
        prep();
        rsp[0] = 8'(n);
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h21); push(P_RS, 0);
        push(P_WR, 8'hA1); push(P_RD, 0); push(P_AK, 1); push(P_SP, 0);
        run("R9", 9, 8'h50, 8'h21, 0, 0, e, c);
        cmp_seq("R9");
        chk("R9", "bad length err", e, 1);
        chk("R9", "bad length count", c, 0);
    endtask

    task automatic t_nack();
        int e, c;
        prep();
        nack_at = 1;
        wr_buf[15:0] = 16'h1111;
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h05); push(P_SP, 0);
        run("R10", 5, 8'h50, 8'h05, 0, 0, e, c);
        cmp_seq("R10");
        chk("R10", "cmd nack err", e, 1);
        prep();
        nack_at = 0;
        push(P_ST, 0); push(P_WR, 8'h23); push(P_SP, 0);
        run("R10", 2, 8'h11, 0, 0, 0, e, c);
        cmp_seq("R10");
        chk("R10", "addr nack err", e, 1);
        prep();
        nack_at = 4;
        for (int i = 0; i < MAXB; i++) wr_buf[i*8 +: 8] = 8'(8'hA0 + i);
        push(P_ST, 0); push(P_WR, 8'hA0); push(P_WR, 8'h20); push(P_WR, 3);
        push(P_WR, 8'hA0); push(P_WR, 8'hA1); push(P_SP, 0);
        run("R10", 8, 8'h50, 8'h20, 0, 3, e, c);
        cmp_seq("R10");
        chk("R10", "data nack err", e, 1);
    endtask

    task automatic t_refuse(input int kind, input int cnt);
        int e, c;
        prep();
        run("R12", kind, 8'h50, 8'h00, 0, cnt, e, c);
        chk("R12", "refused primitives", log_n, 0);
        chk("R12", "refused err", e, 1);
    endtask

    task automatic t_go_busy();
        int n;
        prep();
        wr_buf[7:0] = 8'h66;
        push(P_ST, 0); push(P_WR, 8'h22); push(P_WR, 8'h66); push(P_SP, 0);
        @(negedge clk);
        txn_kind = 4'd1; dev_addr = 7'h11; wr_count = '0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (4) @(negedge clk);
        txn_kind = 4'd2; dev_addr = 7'h3F; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R13", "done seen", int'(done), 1);
        chk("R13", "err after busy go", int'(err), 0);
        repeat (6) @(negedge clk);
        cmp_seq("R13");
        chk("R13", "still idle", int'(busy), 0);
    endtask

    initial begin
        rst_n = 1'b0; go = 1'b0; txn_kind = '0; dev_addr = '0; cmd_byte = '0;
        quick_bit = 1'b0; wr_count = '0; wr_buf = '0;
        for (int i = 0; i < 64; i++) rsp[i] = 8'h00;
        prep();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quick(1);
        t_quick(0);
        t_send();
        t_recv();
        t_byte_rw();
        t_word_rw();
        t_pcall();
        t_blk_wr(3);
        t_blk_wr(32);
        t_blk_rd(3);
        t_blk_rd(32);
        t_blk_rd_bad(0);
        t_blk_rd_bad(33);
        t_nack();
        t_refuse(12, 0);
        t_refuse(8, 0);
        t_refuse(8, 33);
        t_go_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule